// File: doc/BRIEF.md
# Firmware Image Header Validator

This block vets a firmware image held in a byte-wide memory before any part of it is copied into a processor's instruction or data memory. It is started by a one-cycle pulse together with the total image length. It then reads the image through a synchronous byte read port with one cycle of latency. First it confirms a 16-bit checksum kept in the final two bytes. Next it follows a scaled pointer near the start of the image to a section descriptor, decodes the two section placements, and checks that every region it relies on lies inside the image. Finally it makes sure a version string is present.

When the run ends, a one-cycle completion pulse appears with either a pass flag or a nonzero error code. On a pass, the resolved instruction-section and data-section offsets and sizes are also reported. These results stay in place until the next accepted start. The loader that follows uses the reported offsets and sizes as they are.

Top module: `fw_hdr_check`

## Requirements
- R1: A start pulse in the idle state latches the image length and begins a run. A start that arrives while a run is in progress is ignored. Each run ends with `done` high for exactly one cycle, and `pass`, `err_code` and the four section outputs then hold their values until the next accepted start, which clears them.
- R2: An image length below 10 bytes ends the run with error code 2 (short image), with `done` in the cycle after the start, and no read is issued.
- R3: The checksum is CRC-16 with polynomial 0x1021, initial value 0, processed MSB first, one byte per cycle. It covers bytes 0 to len-3. It is compared with the stored value, whose high byte is at len-2 and low byte at len-1. On a mismatch the run ends with error code 1, and no other field is parsed.
- R4: The read port issues at most one address per cycle, marked by `rd_en`, and the data is taken from `rd_data` in the following cycle. No issued address is ever at or above the image length. A passing run issues exactly len + 15 reads.
- R5: The base offset is the little-endian 16-bit value at bytes 8 (low) and 9 (high), shifted left by 12.
- R6: The descriptor starts at base + 0x300. It holds four ignored bytes, then four little-endian 24-bit fields: instruction offset, instruction size, data offset, data size. If base + 0x310 exceeds the length, the run ends with error code 3.
- R7: On a pass, `imem_off` and `dmem_off` report the field offsets plus the base, and `imem_size` and `dmem_size` report the field sizes.
- R8: A section size that is not a multiple of 4 ends the run with error code 4. Checks run in this order: instruction alignment, instruction extent, data alignment, data extent.
- R9: A section whose resolved offset plus size exceeds the length ends the run with error code 5.
- R10: The 64-byte version string starts at the resolved data offset + 0x200. If it does not fit inside the image, or its first byte is zero, the run ends with error code 6.
- R11: A passing run shows `pass` = 1 and `err_code` = 0. `pass` and a nonzero code never appear together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to check an image |
| img_len | input | LEN_W | Image length in bytes, sampled with start |
| rd_en | output | 1 | A read address is issued this cycle |
| rd_addr | output | LEN_W | Byte address to read |
| rd_data | input | 8 | Byte returned one cycle after the address |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Image accepted |
| err_code | output | 3 | 0 none, 1 checksum, 2 short, 3 descriptor, 4 alignment, 5 extent, 6 version |
| imem_off | output | LEN_W | Resolved instruction-section offset |
| imem_size | output | LEN_W | Instruction-section size |
| dmem_off | output | LEN_W | Resolved data-section offset |
| dmem_size | output | LEN_W | Data-section size |

## Verification
Two checks share a single decision cycle. A section can be misaligned and out of range at once, and it is settled by priority. The bench builds images whose size field ends in a nonzero low pair and whose extent also runs past the end. For these it expects the alignment code, and it sweeps every pairing of low size bits across both sections against an arithmetic model. A second coincidence is a new start driven in the very cycle `done` is visible. The bench expects the earlier results to clear on the following cycle and the second run to complete on its own merits.

// File: rtl/fwchk_pkg.sv
// Shared types for the firmware image validator.
// Holds the error code values, the sequencer state encoding and the
// byte-serial CRC-16 step used by the checksum accumulator.
package fwchk_pkg;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_CRC   = 3'd1,
        ERR_SHORT = 3'd2,
        ERR_HDR   = 3'd3,
        ERR_ALIGN = 3'd4,
        ERR_SECT  = 3'd5,
        ERR_VER   = 3'd6
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CRC,
        ST_CRC_CMP,
        ST_PRIM,
        ST_HDR_CHK,
        ST_HDR,
        ST_SEC_CHK,
        ST_VER
    } state_e;

    // One byte through CRC-16, poly 0x1021, MSB first, no reflection.
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                               input logic [7:0]  b);
        logic [15:0] c;
        c = c_in ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/fwchk_crc16.sv
// Byte-serial CRC-16 accumulator.
// Assumes: clr and en are never high together; the value is valid the
// cycle after the last enabled byte.
module fwchk_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import fwchk_pkg::*;

    // Accumulate one byte per enabled cycle, restart from zero on clr.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc <= 16'h0000;
        else if (clr)   crc <= 16'h0000;
        else if (en)    crc <= crc16_step(crc, din);
    end

    a_r3_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 16'h0000));

endmodule

// File: rtl/fwchk_fetch.sv
// Streaming byte fetch engine for a read port with one cycle of latency.
// On go it issues count ascending addresses from base, one per cycle,
// and presents each returned byte with its index one cycle later.
// Assumes: go only while idle, count >= 1.
module fwchk_fetch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] count,
    output logic              issuing,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              byte_vld,
    output logic [ADDR_W-1:0] byte_idx,
    output logic [7:0]        byte_data,
    output logic              fin
);
    logic [ADDR_W-1:0] rem;
    logic [ADDR_W-1:0] iss_idx;
    logic              cap_last;

    // Issue side: walk the address range, stop after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            rd_addr <= '0;
            rem     <= '0;
            iss_idx <= '0;
        end else if (go) begin
            issuing <= 1'b1;
            rd_addr <= base;
            rem     <= count;
            iss_idx <= '0;
        end else if (issuing) begin
            if (rem == ADDR_W'(1)) begin
                issuing <= 1'b0;
            end else begin
                rd_addr <= rd_addr + ADDR_W'(1);
                iss_idx <= iss_idx + ADDR_W'(1);
                rem     <= rem - ADDR_W'(1);
            end
        end
    end

    // Capture side: tag the returned byte with the index issued last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld <= 1'b0;
            byte_idx <= '0;
            cap_last <= 1'b0;
        end else begin
            byte_vld <= issuing;
            byte_idx <= iss_idx;
            cap_last <= issuing && (rem == ADDR_W'(1));
        end
    end

    assign byte_data = rd_data;
    assign fin       = byte_vld && cap_last;

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (issuing && $past(issuing)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));
    a_r4_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !issuing);

endmodule

// File: rtl/fw_hdr_check.sv
// Firmware image validator top level.
// Sequence: length floor, streaming checksum, base pointer, descriptor
// fetch, section checks, version byte. Every fetch is bounds-checked
// against the latched length before it is issued.
// Assumes: the read port returns mem[rd_addr] one cycle after rd_en.
module fw_hdr_check #(
    parameter int LEN_W      = 20,
    parameter int PRIM_LOC   = 8,
    parameter int PRIM_SHIFT = 12,
    parameter int HDR_BASE   = 768,
    parameter int VER_OFS    = 512,
    parameter int VER_LEN    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] img_len,
    output logic             rd_en,
    output logic [LEN_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             done,
    output logic             pass,
    output logic [2:0]       err_code,
    output logic [LEN_W-1:0] imem_off,
    output logic [LEN_W-1:0] imem_size,
    output logic [LEN_W-1:0] dmem_off,
    output logic [LEN_W-1:0] dmem_size
);
    import fwchk_pkg::*;

    localparam int MIN_LEN  = PRIM_LOC + 2;
    localparam int FLD_SKIP = 4;
    localparam int FLD_N    = 12;
    localparam int HDR_LEN  = FLD_SKIP + FLD_N;

    state_e            state;
    err_e              err_q;
    err_e              sec_err;
    logic [LEN_W-1:0]  len_q;
    logic [15:0]       prim_q;
    logic [15:0]       stored_crc;
    logic [8*FLD_N-1:0] hdr_q;

    logic              f_go;
    logic [LEN_W-1:0]  f_base;
    logic [LEN_W-1:0]  f_cnt;
    logic              b_vld;
    logic [LEN_W-1:0]  b_idx;
    logic [7:0]        b_data;
    logic              f_fin;
    logic              crc_clr;
    logic              crc_en;
    logic [15:0]       crc_val;

    logic [31:0] len32, p_off, hdr_end;
    logic [31:0] f_ioff, f_isz, f_doff, f_dsz;
    logic [31:0] ioff_abs, doff_abs;

    // Widen and resolve the decoded fields against the base offset.
    always_comb begin
        len32    = 32'(len_q);
        p_off    = {16'h0000, prim_q} << PRIM_SHIFT;
        hdr_end  = p_off + 32'(HDR_BASE + HDR_LEN);
        f_ioff   = {8'h00, hdr_q[23:0]};
        f_isz    = {8'h00, hdr_q[47:24]};
        f_doff   = {8'h00, hdr_q[71:48]};
        f_dsz    = {8'h00, hdr_q[95:72]};
        ioff_abs = f_ioff + p_off;
        doff_abs = f_doff + p_off;
    end

    // Section checks in priority order: alignment before extent, code before data.
    always_comb begin
        if (f_isz[1:0] != 2'b00)                                   sec_err = ERR_ALIGN;
        else if (ioff_abs + f_isz > len32)                         sec_err = ERR_SECT;
        else if (f_dsz[1:0] != 2'b00)                              sec_err = ERR_ALIGN;
        else if (doff_abs + f_dsz > len32)                         sec_err = ERR_SECT;
        else if (doff_abs + 32'(VER_OFS + VER_LEN) > len32)        sec_err = ERR_VER;
        else                                                       sec_err = ERR_NONE;
    end

    // Fetch requests launched from the decision states.
    always_comb begin
        f_go   = 1'b0;
        f_base = '0;
        f_cnt  = '0;
        case (state)
            ST_IDLE: if (start && (32'(img_len) >= 32'(MIN_LEN))) begin
                f_go  = 1'b1;
                f_cnt = img_len;
            end
            ST_CRC_CMP: if (crc_val == stored_crc) begin
                f_go   = 1'b1;
                f_base = LEN_W'(PRIM_LOC);
                f_cnt  = LEN_W'(2);
            end
            ST_HDR_CHK: if (hdr_end <= len32) begin
                f_go   = 1'b1;
                f_base = LEN_W'(p_off + 32'(HDR_BASE + FLD_SKIP));
                f_cnt  = LEN_W'(FLD_N);
            end
            ST_SEC_CHK: if (sec_err == ERR_NONE) begin
                f_go   = 1'b1;
                f_base = LEN_W'(doff_abs + 32'(VER_OFS));
                f_cnt  = LEN_W'(1);
            end
            default: ;
        endcase
    end

    assign crc_clr = f_go && (state == ST_IDLE);
    assign crc_en  = (state == ST_CRC) && b_vld && (b_idx < len_q - LEN_W'(2));

    fwchk_fetch #(.ADDR_W(LEN_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (f_go),
        .base      (f_base),
        .count     (f_cnt),
        .issuing   (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .byte_vld  (b_vld),
        .byte_idx  (b_idx),
        .byte_data (b_data),
        .fin       (f_fin)
    );

    fwchk_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (b_data),
        .crc   (crc_val)
    );

    // Sequencer: step through the checks and publish the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            err_q      <= ERR_NONE;
            pass       <= 1'b0;
            done       <= 1'b0;
            len_q      <= '0;
            prim_q     <= '0;
            stored_crc <= '0;
            hdr_q      <= '0;
            imem_off   <= '0;
            imem_size  <= '0;
            dmem_off   <= '0;
            dmem_size  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    pass       <= 1'b0;
                    err_q      <= ERR_NONE;
                    imem_off   <= '0;
                    imem_size  <= '0;
                    dmem_off   <= '0;
                    dmem_size  <= '0;
                    len_q      <= img_len;
                    stored_crc <= '0;
                    if (f_go) begin
                        state <= ST_CRC;
                    end else begin
                        err_q <= ERR_SHORT;
                        done  <= 1'b1;
                    end
                end
                ST_CRC: begin
                    if (b_vld && !crc_en) stored_crc <= {stored_crc[7:0], b_data};
                    if (f_fin) state <= ST_CRC_CMP;
                end
                ST_CRC_CMP: begin
                    if (f_go) begin
                        state <= ST_PRIM;
                    end else begin
                        err_q <= ERR_CRC;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_PRIM: begin
                    if (b_vld) prim_q <= {b_data, prim_q[15:8]};
                    if (f_fin) state <= ST_HDR_CHK;
                end
                ST_HDR_CHK: begin
                    if (f_go) begin
                        state <= ST_HDR;
                    end else begin
                        err_q <= ERR_HDR;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_HDR: begin
                    if (b_vld) hdr_q <= {b_data, hdr_q[8*FLD_N-1:8]};
                    if (f_fin) state <= ST_SEC_CHK;
                end
                ST_SEC_CHK: begin
                    if (f_go) begin
                        state <= ST_VER;
                    end else begin
                        err_q <= sec_err;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_VER: if (b_vld) begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                    if (b_data == 8'h00) begin
                        err_q <= ERR_VER;
                    end else begin
                        pass      <= 1'b1;
                        imem_off  <= LEN_W'(ioff_abs);
                        imem_size <= LEN_W'(f_isz);
                        dmem_off  <= LEN_W'(doff_abs);
                        dmem_size <= LEN_W'(f_dsz);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign err_code = err_q;

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(pass) && $stable(err_code) && $stable(imem_off) && $stable(dmem_size)));
    a_r2_short: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && (32'(img_len) < 32'(MIN_LEN))) |=> (done && err_code == 3'd2 && !rd_en));
    a_r4_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < len_q));
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (err_code == 3'd0));

endmodule

// File: tb/fw_hdr_check_test.sv
// Self-checking bench: builds images in a byte memory, runs the validator
// and compares against an arithmetic model of the requirements.
module fw_hdr_check_test;

    localparam int LW    = 20;
    localparam int MEM_N = 6144;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] img_len = '0;
    logic          rd_en;
    logic [LW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;
    logic          done, pass;
    logic [2:0]    err_code;
    logic [LW-1:0] imem_off, imem_size, dmem_off, dmem_size;

    logic [7:0] mem [MEM_N];

    int checks = 0, fails = 0, cycles = 0;
    int cur_len = 0, oob_reads = 0, nreads = 0;

    always #10 clk = ~clk;

    fw_hdr_check uut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .pass(pass), .err_code(err_code),
        .imem_off(imem_off), .imem_size(imem_size),
        .dmem_off(dmem_off), .dmem_size(dmem_size)
    );

    always_ff @(posedge clk)
        rd_data <= (int'(rd_addr) < MEM_N) ? mem[int'(rd_addr)] : 8'h00;

    // R4 monitor: count issued reads and any that reach the image end.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && rd_en) begin
            nreads <= nreads + 1;
            if (int'(rd_addr) >= cur_len) oob_reads <= oob_reads + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c = c ^ {mem[i], 8'h00};
            for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic longint le24(input longint a);
        return longint'(mem[a]) | (longint'(mem[a+1]) << 8) | (longint'(mem[a+2]) << 16);
    endfunction

    // Expected verdict from the requirements.
    task automatic model(input int len, output int code, output longint io, output longint isz,
                         output longint dof, output longint dsz);
        longint p, h;
        code = 0; io = 0; isz = 0; dof = 0; dsz = 0;
        if (len < 10) begin code = 2; return; end
        if (ref_crc(len - 2) != {mem[len-2], mem[len-1]}) begin code = 1; return; end
        p = (longint'(mem[8]) | (longint'(mem[9]) << 8)) << 12;
        if (p + 'h310 > len) begin code = 3; return; end
        h = p + 'h304;
        io = le24(h) + p; isz = le24(h + 3); dof = le24(h + 6) + p; dsz = le24(h + 9);
        if (isz % 4 != 0) code = 4;
        else if (io + isz > len) code = 5;
        else if (dsz % 4 != 0) code = 4;
        else if (dof + dsz > len) code = 5;
        else if (dof + 'h240 > len) code = 6;
        else if (mem[dof + 'h200] == 8'h00) code = 6;
    endtask

    task automatic seal(input int len);
        logic [15:0] c;
        if (len < 2) return;
        c = ref_crc(len - 2);
        mem[len-2] = c[15:8];
        mem[len-1] = c[7:0];
    endtask

    task automatic build(input int len, input int prim, input int io, input int isz,
                         input int dof, input int dsz, input logic [7:0] ver);
        int h;
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
        mem[8] = 8'(prim); mem[9] = 8'(prim >> 8);
        h = (prim << 12) + 'h300;
        if (h + 16 <= MEM_N) begin
            for (int k = 0; k < 4; k++) mem[h+k] = 8'h00;
            for (int k = 0; k < 3; k++) begin
                mem[h+4+k]  = 8'(io  >> (8*k));
                mem[h+7+k]  = 8'(isz >> (8*k));
                mem[h+10+k] = 8'(dof >> (8*k));
                mem[h+13+k] = 8'(dsz >> (8*k));
            end
        end
        if ((prim << 12) + dof + 'h200 < MEM_N) mem[(prim << 12) + dof + 'h200] = ver;
        seal(len);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic run(input int len, input string req);
        int code;
        longint io, isz, dof, dsz;
        model(len, code, io, isz, dof, dsz);
        cur_len = len;
        @(negedge clk);
        start = 1'b1; img_len = LW'(len);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(done && err_code == 3'(code) && pass == (code == 0), req, longint'(err_code), longint'(code));
        if (code == 0)
            check(imem_off == LW'(io) && imem_size == LW'(isz) && dmem_off == LW'(dof) && dmem_size == LW'(dsz),
                  "R7", longint'(dmem_off), dof);
    endtask

    initial begin
        int r0;
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // Reset state
        check(!done && !pass && err_code == 3'd0 && !rd_en, "R1", longint'(err_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4, R5, R6, R7, R11: basic passing image and exact read count
        build(1024, 0, 'h10, 'h40, 'h40, 'h100, 8'h41);
        r0 = nreads;
        run(1024, "R11");
        check(nreads - r0 == 1024 + 15, "R4", nreads - r0, 1024 + 15);

        // R1: result holds while idle
        repeat (5) @(negedge clk);
        check(pass && err_code == 3'd0 && imem_off == LW'('h10), "R1", longint'(imem_off), 'h10);

        // R2: short-length sweep and the first accepted length
        for (int l = 0; l < 12; l++) begin
            build(l, 0, 0, 0, 0, 0, 8'h41);
            run(l, l < 10 ? "R2" : "R6");
        end

        // R3: single corrupted byte at several positions
        foreach (r0_pos[i]) ;
        for (int k = 0; k < 5; k++) begin
            int pos;
            pos = (k == 0) ? 0 : (k == 1) ? 500 : (k == 2) ? 1021 : (k == 3) ? 1022 : 1023;
            build(1024, 0, 'h10, 'h40, 'h40, 'h100, 8'h41);
            mem[pos] = mem[pos] ^ 8'h10;
            run(1024, "R3");
        end

        // R8: all pairings of low size bits; extent overrun alongside misalignment
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                build(1024, 0, 'h10, 'h40 + a, 'h40, 'h100 + b, 8'h41);
                run(1024, "R8");
            end
        build(1024, 0, 'h10, 'h1003, 'h40, 'h100, 8'h41);
        run(1024, "R8");

        // R9: section extents at and around the image end
        for (int d = -4; d <= 4; d += 4) begin
            build(1024, 0, 'h100, 1024 - 'h100 + d, 'h40, 'h100, 8'h41);
            run(1024, "R9");
            build(1024, 0, 'h10, 'h40, 'h40, 1024 - 'h40 + d, 8'h41);
            run(1024, "R9");
        end

        // R10: version string fit boundary and zero first byte
        for (int d = -1; d <= 1; d++) begin
            build(1024, 0, 'h10, 'h40, 1024 - 'h240 + d, 0, 8'h41);
            run(1024, "R10");
        end
        build(1024, 0, 'h10, 'h40, 'h40, 'h100, 8'h00);
        run(1024, "R10");

        // R6: descriptor fit boundary
        build('h30F, 0, 'h10, 0, 'h40, 0, 8'h41);
        run('h30F, "R6");
        build('h310, 0, 'h10, 0, 'h40, 0, 8'h41);
        run('h310, "R6");

        // R5: nonzero base offset, and a base that pushes the descriptor out
        build(4900, 1, 'h20, 'h80, 'h20, 'h40, 8'h5A);
        run(4900, "R5");
        build(4900, 2, 'h20, 'h80, 'h20, 'h40, 8'h5A);
        run(4900, "R5");

        // R1: start during a run is ignored
        build(1024, 0, 'h10, 'h40, 'h40, 'h100, 8'h41);
        cur_len = 1024;
        @(negedge clk); start = 1'b1; img_len = LW'(1024);
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; img_len = LW'(5);
        @(negedge clk); start = 1'b0;
        wait_done();
        check(done && pass && err_code == 3'd0, "R1", longint'(err_code), 0);

        // R1: new start in the cycle done is visible clears old results
        build(1024, 0, 'h10, 'h40, 'h40, 'h100, 8'h41);
        @(negedge clk); start = 1'b1; img_len = LW'(1024);
        @(negedge clk); start = 1'b0;
        wait_done();
        start = 1'b1; img_len = LW'(1024);
        @(negedge clk); start = 1'b0;
        check(!done && !pass && err_code == 3'd0 && imem_off == '0, "R1", longint'(pass), 0);
        wait_done();
        check(done && pass && dmem_size == LW'('h100), "R1", longint'(dmem_size), 'h100);

        // R4: no address at or beyond the image end across all runs
        check(oob_reads == 0, "R4", oob_reads, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    int r0_pos [1];

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles >= 190000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule